// File: doc/BRIEF.md
# Privileged State Restore Sequencer

This block is the host side of a coprocessor state-restore exchange. A one-cycle `start` pulse begins the sequence. It carries a 16-bit frame header word and a flag that says whether the host runs at supervisor level. The sequencer talks to the coprocessor's register window over a simple request/ready bus, with one access at a time. In supervisor mode it writes the header to the restore register and reads that register back. The coprocessor answers with either a usable header or a rejection code. For a usable header, the sequencer streams the frame body from a valid/ready operand source into the operand register, one 32-bit word per bus write.

Each accepted start ends in exactly one of three one-cycle outcome pulses:
- `done` when the frame has been delivered.
- `priv_violation` when the host was not in supervisor mode. In that case the coprocessor window is never touched.
- `format_error` after the coprocessor rejected the header. Before this pulse the sequencer writes the abort mask to the control register.

Top module: `restore_seq`

## Requirements
- R1: A start while idle with `supervisor` low gives a `priv_violation` pulse on the next cycle. No bus request is made for that start.
- R2: A start while idle with `supervisor` high first issues a write of `fmt_word` to offset 0x06, the restore register. It then issues a read of offset 0x06.
- R3: If the word read back is not 0x0200, its bits 7:0 give a byte count. The sequencer issues floor(count/4) writes to offset 0x10, the operand register. These carry the operand stream words in order. It then pulses `done`.
- R4: If the word read back equals 0x0200, the sequencer writes 0x0001 to offset 0x02, the control register. It then pulses `format_error`. No operand write is made.
- R5: While `bus_req` is high and `bus_ready` is low, `bus_addr`, `bus_we` and `bus_wdata` hold their values. `bus_req` falls in the cycle after the handshake, so at most one access is outstanding.
- R6: A byte count below 4, including 0, makes no operand access. `done` pulses straight after the read-back completes.
- R7: `done`, `priv_violation` and `format_error` are each one cycle wide. Exactly one of them pulses for each accepted start, and never two at once. After reset all outputs are low.
- R8: A start that arrives while `busy` is high is ignored. It adds no pulse and no bus access.
- R9: An operand word is consumed only in a cycle where `op_valid` and `op_ready` are both high. While `op_valid` is low, no operand write is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one restore sequence |
| supervisor | input | 1 | High when the host runs at supervisor level |
| fmt_word | input | CIR_W | Frame header word to offer the coprocessor |
| op_valid | input | 1 | Operand source has a word |
| op_data | input | DATA_W | Operand source word |
| op_ready | output | 1 | Sequencer takes the operand word this cycle |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | ADDR_W | Register offset of the access |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | CIR_W | Read data, valid with `bus_ready` |
| bus_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Frame delivered (pulse) |
| priv_violation | output | 1 | Start at user level (pulse) |
| format_error | output | 1 | Header rejected (pulse) |

## Verification
The bench goes after the user-level start. A design that checked the privilege flag too late would show a restore-register write in the bus log. It also drives a read-back of the rejection code. A design that skipped the abort would pulse `format_error` with no control-register write, and one that ignored the code would stream operand words instead. Byte counts of 0 and 3 catch a design that underflows its word counter and runs away on the bus. A stalling operand source, a slow bus and a second start during a run catch:
- words taken twice or out of order,
- data that changes mid-access,
- a start that was not ignored and so shows up as an extra pulse.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_CIR_W  = 16;
  localparam int unsigned DEF_CNT_W  = 8;

  localparam logic [7:0]  DEF_OFF_CTRL    = 8'h02;
  localparam logic [7:0]  DEF_OFF_RESTORE = 8'h06;
  localparam logic [7:0]  DEF_OFF_OPER    = 8'h10;
  localparam logic [15:0] DEF_ABORT_MASK  = 16'h0001;
  localparam logic [15:0] DEF_BAD_FMT     = 16'h0200;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WR_FMT = 3'd1,
    ST_RD_FMT = 3'd2,
    ST_FETCH  = 3'd3,
    ST_WR_OP  = 3'd4,
    ST_ABORT  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/cir_bus_port.sv
module cir_bus_port #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CIR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ack,
  output logic [CIR_W-1:0]  cmd_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [CIR_W-1:0]  bus_rdata,
  input  logic              bus_ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      cmd_ack   <= 1'b0;
      cmd_rdata <= '0;
    end else begin
      cmd_ack <= 1'b0;
      if (bus_req) begin
        if (bus_ready) begin
          bus_req   <= 1'b0;
          cmd_ack   <= 1'b1;
          cmd_rdata <= bus_rdata;
        end
      end else if (cmd_go) begin
        bus_req   <= 1'b1;
        bus_we    <= cmd_we;
        bus_addr  <= cmd_addr;
        bus_wdata <= cmd_wdata;
      end
    end
  end

  // R5: request fields stay put until the handshake
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R5: request released right after ready
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ready |=> !bus_req);

  // R5: the sequencer never launches over an outstanding access
  p_single_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_go |-> !bus_req);
endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (dec) begin
      remain <= remain - 1'b1;
    end
  end

  assign last = (remain == CNT_W'(1));

  // R3: never count below zero
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    dec |-> remain != '0);
endmodule

// File: rtl/restore_seq.sv
module restore_seq
  import rsq_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned CIR_W       = DEF_CIR_W,
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter logic [ADDR_W-1:0] OFF_CTRL    = ADDR_W'(DEF_OFF_CTRL),
  parameter logic [ADDR_W-1:0] OFF_RESTORE = ADDR_W'(DEF_OFF_RESTORE),
  parameter logic [ADDR_W-1:0] OFF_OPER    = ADDR_W'(DEF_OFF_OPER),
  parameter logic [CIR_W-1:0]  ABORT_MASK  = CIR_W'(DEF_ABORT_MASK),
  parameter logic [CIR_W-1:0]  BAD_FMT     = CIR_W'(DEF_BAD_FMT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              supervisor,
  input  logic [CIR_W-1:0]  fmt_word,
  input  logic              op_valid,
  input  logic [DATA_W-1:0] op_data,
  output logic              op_ready,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [CIR_W-1:0]  bus_rdata,
  input  logic              bus_ready,
  output logic              busy,
  output logic              done,
  output logic              priv_violation,
  output logic              format_error
);
  localparam int unsigned WC_W = CNT_W - 2;
  localparam int unsigned PAD_W = DATA_W - CIR_W;

  seq_state_t        state;
  logic              go;
  logic              cmd_we;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata;
  logic              ack;
  logic [CIR_W-1:0]  ack_rdata;
  logic              cnt_load;
  logic              cnt_dec;
  logic              cnt_last;
  logic [WC_W-1:0]   word_cnt;
  logic              hdr_bad;
  logic              hdr_empty;

  cir_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CIR_W(CIR_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .cmd_go    (go),
    .cmd_we    (cmd_we),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_ack   (ack),
    .cmd_rdata (ack_rdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready)
  );

  assign word_cnt  = ack_rdata[CNT_W-1:2];
  assign hdr_bad   = (ack_rdata == BAD_FMT);
  assign hdr_empty = (word_cnt == '0);
  assign cnt_load  = (state == ST_RD_FMT) && ack;
  assign cnt_dec   = (state == ST_WR_OP) && ack;

  frame_counter #(.CNT_W(WC_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (word_cnt),
    .dec      (cnt_dec),
    .last     (cnt_last)
  );

  assign op_ready = (state == ST_FETCH);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      go             <= 1'b0;
      cmd_we         <= 1'b0;
      cmd_addr       <= '0;
      cmd_wdata      <= '0;
      done           <= 1'b0;
      priv_violation <= 1'b0;
      format_error   <= 1'b0;
    end else begin
      go             <= 1'b0;
      done           <= 1'b0;
      priv_violation <= 1'b0;
      format_error   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (!supervisor) begin
              priv_violation <= 1'b1;
            end else begin
              state     <= ST_WR_FMT;
              go        <= 1'b1;
              cmd_we    <= 1'b1;
              cmd_addr  <= OFF_RESTORE;
              cmd_wdata <= {{PAD_W{1'b0}}, fmt_word};
            end
          end
        end
        ST_WR_FMT: begin
          if (ack) begin
            state    <= ST_RD_FMT;
            go       <= 1'b1;
            cmd_we   <= 1'b0;
            cmd_addr <= OFF_RESTORE;
          end
        end
        ST_RD_FMT: begin
          if (ack) begin
            if (hdr_bad) begin
              state     <= ST_ABORT;
              go        <= 1'b1;
              cmd_we    <= 1'b1;
              cmd_addr  <= OFF_CTRL;
              cmd_wdata <= {{PAD_W{1'b0}}, ABORT_MASK};
            end else if (hdr_empty) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (op_valid) begin
            state     <= ST_WR_OP;
            go        <= 1'b1;
            cmd_we    <= 1'b1;
            cmd_addr  <= OFF_OPER;
            cmd_wdata <= op_data;
          end
        end
        ST_WR_OP: begin
          if (ack) begin
            if (cnt_last) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_ABORT: begin
          if (ack) begin
            state        <= ST_IDLE;
            format_error <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: user-level start is refused without touching the bus
  p_priv_r1: assert property (@(posedge clk) disable iff (rst)
    start && !supervisor && !busy |=> priv_violation && !bus_req);

  // R4: a format error always follows a completed abort write to control
  p_abort_first_r4: assert property (@(posedge clk) disable iff (rst)
    format_error |-> $past(bus_req && bus_ready && bus_we && bus_addr == OFF_CTRL, 2));

  // R7: never two outcomes together
  p_one_outcome_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, priv_violation, format_error}));

  // R7: outcomes are single-cycle
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (done || priv_violation || format_error) |=> !(done || priv_violation || format_error));

  // R8: a start during a run raises no privilege pulse
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> !priv_violation);
endmodule

// File: tb/test_restore_seq.sv
module test_restore_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        supervisor = 1'b0;
  logic [15:0] fmt_word = '0;
  logic        op_valid = 1'b0;
  logic [31:0] op_data = '0;
  logic        op_ready;
  logic        bus_req;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;
  logic        busy;
  logic        done;
  logic        priv_violation;
  logic        format_error;

  restore_seq i_restore_seq (
    .clk(clk), .rst(rst), .start(start), .supervisor(supervisor), .fmt_word(fmt_word),
    .op_valid(op_valid), .op_data(op_data), .op_ready(op_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .busy(busy), .done(done),
    .priv_violation(priv_violation), .format_error(format_error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // bus slave and access log
  int          lat = 0;
  int          wait_cnt = 0;
  logic [15:0] rb_value = '0;
  int          n_log = 0;
  logic [7:0]  log_addr [16];
  logic        log_we   [16];
  logic [31:0] log_data [16];

  // operand source
  int          src_n = 0;
  int          src_idx = 0;
  logic [31:0] src_base = '0;
  bit          stall = 1'b0;
  bit          phase = 1'b0;
  bit          took = 1'b0;

  // pulse counters
  int n_done = 0, n_priv = 0, n_ferr = 0;

  task automatic report(input string msg);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $display("%s", msg);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    took = op_valid && op_ready;
    if (cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      report("watchdog expired");
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      bus_ready = 1'b0;
      wait_cnt  = 0;
    end else if (bus_ready) begin
      bus_ready = 1'b0;
    end else if (bus_req) begin
      if (wait_cnt >= lat) begin
        bus_ready = 1'b1;
        bus_rdata = rb_value;
        wait_cnt  = 0;
        if (n_log < 16) begin
          log_addr[n_log] = bus_addr;
          log_we[n_log]   = bus_we;
          log_data[n_log] = bus_we ? bus_wdata : {16'h0, rb_value};
        end
        n_log++;
      end else begin
        wait_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (took) begin
      src_idx++;
      took = 1'b0;
    end
    phase    = ~phase;
    op_valid = (src_idx < src_n) && (!stall || phase);
    op_data  = src_base + 32'(src_idx);
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (done) n_done++;
      if (priv_violation) n_priv++;
      if (format_error) n_ferr++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_access(input string req, input int idx, input logic we,
                              input logic [7:0] addr, input logic [31:0] data);
    check(log_we[idx] == we && log_addr[idx] == addr, req, $sformatf("access %0d addr/we", idx),
          {23'h0, log_we[idx], log_addr[idx]}, {23'h0, we, addr});
    check(log_data[idx] == data, req, $sformatf("access %0d data", idx), log_data[idx], data);
  endtask

  task automatic run(input bit sup, input logic [15:0] fmt, input logic [15:0] rb,
                     input int nsrc, input logic [31:0] base, input int latency,
                     input bit stl, input bit poke);
    @(negedge clk);
    n_log = 0; n_done = 0; n_priv = 0; n_ferr = 0;
    rb_value = rb; lat = latency; stall = stl;
    src_n = nsrc; src_idx = 0; src_base = base;
    start = 1'b1; supervisor = sup; fmt_word = fmt;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; supervisor = 1'b0;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (n_done + n_priv + n_ferr > 0) break;
    end
    repeat (6) @(negedge clk);
    src_n = 0;
  endtask

  task automatic t_reset;
    check(!bus_req && !busy, "R7", "reset bus_req/busy", {30'h0, bus_req, busy}, 32'h0);
    check(!done && !priv_violation && !format_error && !op_ready, "R7", "reset outputs",
          {28'h0, done, priv_violation, format_error, op_ready}, 32'h0);
  endtask

  task automatic t_user;
    run(1'b0, 16'h1234, 16'h0010, 4, 32'h0, 1, 1'b0, 1'b0);
    check(n_priv == 1, "R1", "priv pulses", n_priv, 1);
    check(n_log == 0, "R1", "bus accesses", n_log, 0);
    check(n_done == 0 && n_ferr == 0, "R7", "other pulses", n_done + n_ferr, 0);
  endtask

  task automatic t_valid;
    run(1'b1, 16'h3A10, 16'h0010, 4, 32'hA500_0000, 2, 1'b0, 1'b0);
    check(n_log == 6, "R3", "access count", n_log, 6);
    check_access("R2", 0, 1'b1, 8'h06, 32'h0000_3A10);
    check_access("R2", 1, 1'b0, 8'h06, 32'h0000_0010);
    for (int i = 0; i < 4; i++) check_access("R3", 2 + i, 1'b1, 8'h10, 32'hA500_0000 + i);
    check(n_done == 1 && n_priv == 0 && n_ferr == 0, "R7", "one done pulse",
          {n_done[7:0], n_priv[7:0], n_ferr[7:0]}, 32'h010000);
    check(src_idx == 4, "R9", "words consumed", src_idx, 4);
  endtask

  task automatic t_bad;
    run(1'b1, 16'h0077, 16'h0200, 4, 32'hBB00_0000, 1, 1'b0, 1'b0);
    check(n_log == 3, "R4", "access count", n_log, 3);
    check_access("R2", 0, 1'b1, 8'h06, 32'h0000_0077);
    check_access("R4", 2, 1'b1, 8'h02, 32'h0000_0001);
    check(n_ferr == 1 && n_done == 0, "R4", "format error pulse",
          {n_ferr[15:0], n_done[15:0]}, 32'h0001_0000);
    check(src_idx == 0, "R4", "no operand consumed", src_idx, 0);
  endtask

  task automatic t_short(input logic [15:0] rb);
    run(1'b1, 16'h0100, rb, 4, 32'hCC00_0000, 0, 1'b0, 1'b0);
    check(n_log == 2, "R6", "access count short frame", n_log, 2);
    check(n_done == 1, "R6", "done pulse short frame", n_done, 1);
    check(src_idx == 0, "R6", "no operand consumed", src_idx, 0);
  endtask

  task automatic t_stall;
    run(1'b1, 16'h0C0C, 16'h000C, 3, 32'hD000_0100, 0, 1'b1, 1'b0);
    check(n_log == 5, "R9", "access count stalled", n_log, 5);
    for (int i = 0; i < 3; i++) check_access("R9", 2 + i, 1'b1, 8'h10, 32'hD000_0100 + i);
    check(n_done == 1, "R3", "done after stalled stream", n_done, 1);
  endtask

  task automatic t_poke;
    run(1'b1, 16'h0808, 16'h0008, 2, 32'hE000_0000, 3, 1'b0, 1'b1);
    check(n_priv == 0 && n_done == 1, "R8", "busy start ignored",
          {n_priv[15:0], n_done[15:0]}, 32'h0000_0001);
    check(n_log == 4, "R8", "access count with poke", n_log, 4);
    check_access("R5", 3, 1'b1, 8'h10, 32'hE000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_user();
    t_valid();
    t_bad();
    t_short(16'h0000);
    t_short(16'h0003);
    t_stall();
    t_poke();
    report("run complete");
  end
endmodule